// File: doc/BRIEF.md
# Early-Exit Serial Multiplier over GF(2^283)

This block multiplies two elements of the binary field GF(2^283) held in polynomial basis, returning A·B reduced modulo the field polynomial f(x) = x^283 + x^12 + x^7 + x^5 + 1. It is a shift-and-add engine. The multiplier operand B sits in a right-shift register. The multiplicand A is stepped through A·x, A·x^2, … with reduction after every step. A is XOR-added into the accumulator whenever the lowest bit of B is one.

Two features reduce latency. First, the run ends as soon as the shifted B register becomes zero, so a short multiplier finishes in a few cycles. Second, when the low bits of B are zero, the block skips up to five positions in one cycle. It shifts B right by that amount and multiplies A by the matching power of x, with full reduction. A higher level starts the block with a one-cycle strobe. It then waits for the one-cycle done pulse, and can use that pulse to stop the block's clock.

Top module: `gf2m_serial_mult`

## Requirements
- R1: The result is A·B mod f(x), where f(x) = x^283 + x^12 + x^7 + x^5 + 1. Bit i of every 283-bit vector is the coefficient of x^i. Addition is XOR and a coefficient product is AND.
- R2: A start strobe seen while idle loads A and B and clears the accumulator. A start strobe seen while a multiply is in progress is ignored, and the running product is unaffected.
- R3: Completion is signalled by done_o high for exactly one clock cycle. It is raised once the shifted B register has become zero.
- R4: Each busy cycle advances B by a number of positions. If bit 0 of B is one, the block accumulates A and advances one position. Otherwise it advances by the number of trailing zeros of B, capped at 5. With s such advances, done_o rises s+1 clock edges after the edge that loaded the operands.
- R5: If B is zero at start, done_o rises one clock edge after the load edge and result_o is zero.
- R6: After done_o, result_o holds its value until the next accepted start.
- R7: After synchronous active-low reset, done_o is low and result_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe; sampled only while idle |
| a_i | input | 283 | Multiplicand A, polynomial basis |
| b_i | input | 283 | Multiplier B, polynomial basis |
| result_o | output | 283 | Product accumulator; final once done_o pulses |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Accumulation and reduction can fall in the same cycle. This happens when bit 0 of B is one while the top bit of A is set: the accumulator takes the old A as the register is reduced into A·x. All-ones and dense random operands make this happen on almost every cycle. Products are compared against a bit-by-bit reference model in the bench, and latency is compared against a step count derived from R4. A start strobe during a busy run also falls in the same cycle as a skip or accumulate step. The bench confirms that the product of the first operands still appears.

// File: rtl/gf2m_mul_pkg.sv
// Package: field constants shared by the serial multiplier and its bench.
// Assumes a pentanomial modulus whose degree equals FIELD_W.
package gf2m_mul_pkg;
    localparam int FIELD_W = 283;
    // Low FIELD_W bits of f(x) = x^283 + x^12 + x^7 + x^5 + 1
    localparam logic [FIELD_W-1:0] FIELD_POLY = FIELD_W'(16'h10A1);
    localparam int MAX_SKIP_DEF = 5;
endpackage

// File: rtl/gf2m_zero_skip.sv
// Module: decides how far B advances this cycle and whether A is accumulated.
// Assumes MAX_SKIP < W. Output is meaningful only when B is nonzero.
module gf2m_zero_skip #(
    parameter int W        = 283,
    parameter int MAX_SKIP = 5,
    parameter int SKIP_W   = 3
) (
    input  logic [W-1:0]      b_i,
    output logic [SKIP_W-1:0] step_o,
    output logic              acc_o
);
    // Purpose: first set bit among the low MAX_SKIP bits picks the step.
    always_comb begin
        logic found;
        found  = 1'b0;
        acc_o  = b_i[0];
        step_o = SKIP_W'(MAX_SKIP);
        for (int s = 0; s < MAX_SKIP; s++) begin
            if (!found && b_i[s]) begin
                step_o = (s == 0) ? SKIP_W'(1) : SKIP_W'(s);
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/gf2m_xpow_shift.sv
// Module: multiplies A by x^k modulo f(x), k in 1..MAX_SKIP.
// One reduced shift stage per power; a stage is built for each k by generate.
module gf2m_xpow_shift #(
    parameter int           W        = 283,
    parameter logic [W-1:0] POLY     = '0,
    parameter int           MAX_SKIP = 5,
    parameter int           SKIP_W   = 3
) (
    input  logic [W-1:0]      a_i,
    input  logic [SKIP_W-1:0] k_i,
    output logic [W-1:0]      a_o
);
    logic [W-1:0] stage [MAX_SKIP+1];

    assign stage[0] = a_i;

    generate
        for (genvar s = 1; s <= MAX_SKIP; s++) begin : g_stage
            // Purpose: one multiply-by-x with reduction of the carried-out term.
            assign stage[s] = {stage[s-1][W-2:0], 1'b0} ^ (stage[s-1][W-1] ? POLY : '0);
        end
    endgenerate

    // Purpose: pick the stage matching the requested power.
    always_comb begin
        a_o = stage[1];
        for (int s = 1; s <= MAX_SKIP; s++) begin
            if (k_i == SKIP_W'(s)) a_o = stage[s];
        end
    end
endmodule

// File: rtl/gf2m_serial_mult.sv
// Module: early-exit, zero-skipping shift-and-add multiplier over GF(2^W).
// Assumes start_i is a strobe; operands are sampled only on an accepted start.
module gf2m_serial_mult
    import gf2m_mul_pkg::*;
#(
    parameter int           W        = FIELD_W,
    parameter logic [W-1:0] POLY     = FIELD_POLY,
    parameter int           MAX_SKIP = MAX_SKIP_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] result_o,
    output logic         done_o
);
    localparam int SKIP_W = $clog2(MAX_SKIP + 1);

    logic              busy_q, done_q;
    logic [W-1:0]      a_q, b_q, c_q;
    logic [W-1:0]      a_next;
    logic [SKIP_W-1:0] step;
    logic              acc;

    gf2m_zero_skip #(.W(W), .MAX_SKIP(MAX_SKIP), .SKIP_W(SKIP_W)) skip_i (
        .b_i(b_q), .step_o(step), .acc_o(acc)
    );

    gf2m_xpow_shift #(.W(W), .POLY(POLY), .MAX_SKIP(MAX_SKIP), .SKIP_W(SKIP_W)) xpow_i (
        .a_i(a_q), .k_i(step), .a_o(a_next)
    );

    // Purpose: load on start, step while B is nonzero, pulse done on exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            a_q    <= '0;
            b_q    <= '0;
            c_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    a_q    <= a_i;
                    b_q    <= b_i;
                    c_q    <= '0;
                    busy_q <= 1'b1;
                end
            end else if (b_q == '0) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                if (acc) c_q <= c_q ^ a_q;
                a_q <= a_next;
                b_q <= b_q >> step;
            end
        end
    end

    assign result_o = c_q;
    assign done_o   = done_q;

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    assert_done_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(busy_q) && ($past(b_q) == '0)));

    assert_b_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && b_q != '0) |=> (b_q < $past(b_q)));

    assert_step_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && b_q != '0) |-> (step >= SKIP_W'(1) && step <= SKIP_W'(MAX_SKIP)));

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start_i) |=> $stable(c_q));

    assert_busy_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q);

    initial begin
        assert_skip_fits_R4: assert (MAX_SKIP >= 1 && MAX_SKIP < W);
    end
endmodule

// File: tb/gf2m_serial_mult_tb_top.sv
// Bench: fixed-seed random and directed operands, checked against a
// bit-by-bit reference product and a step count derived from R4.
module gf2m_serial_mult_tb_top;
    import gf2m_mul_pkg::*;
    localparam int W = FIELD_W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic [W-1:0] result_o;
    logic         done_o;

    int checks = 0;
    int errors = 0;

    gf2m_serial_mult dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .a_i(a_i), .b_i(b_i), .result_o(result_o), .done_o(done_o)
    );

    always #4 clk = ~clk;

    function automatic logic [W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
        logic [W-1:0] c;
        c = '0;
        for (int i = 0; i < W; i++) begin
            if (b[i]) c ^= a;
            a = {a[W-2:0], 1'b0} ^ (a[W-1] ? FIELD_POLY : '0);
        end
        return c;
    endfunction

    function automatic int ref_steps(logic [W-1:0] b);
        int n;
        int t;
        n = 0;
        while (b != '0) begin
            if (b[0]) b = b >> 1;
            else begin
                t = 0;
                while (t < 5 && !b[t]) t++;
                b = b >> t;
            end
            n++;
        end
        return n;
    endfunction

    function automatic logic [W-1:0] rand_elem();
        logic [W-1:0] v;
        v = '0;
        for (int i = 0; i < 9; i++) v = (v << 32) | W'($urandom());
        return v;
    endfunction

    task automatic check_vec(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Runs one multiply; interfere pulses start with other operands mid-run.
    task automatic run_mul(logic [W-1:0] a, logic [W-1:0] b, bit interfere);
        int cyc;
        logic [W-1:0] held;
        @(negedge clk);
        a_i = a; b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (!done_o && cyc < 400) begin
            if (interfere && cyc == 2) begin
                a_i = ~a; b_i = ~b; start_i = 1'b1;
            end else start_i = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        // R1 product; R2 when interfered (first operands must win)
        check_vec(interfere ? "R2" : "R1", result_o, ref_mul(a, b));
        if (!interfere) check_int("R4", cyc, ref_steps(b) + 1);
        held = result_o;
        @(negedge clk);
        check_int("R3", int'(done_o), 0);
        repeat (2) @(negedge clk);
        check_vec("R6", result_o, held);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] ra, rb;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        check_int("R7", int'(done_o), 0);
        check_vec("R7", result_o, '0);

        // R5: zero multiplier finishes one edge after load with zero result
        run_mul(rand_elem(), '0, 1'b0);
        check_vec("R5", result_o, '0);
        // R1 directed: one, all-ones, zero multiplicand
        run_mul(rand_elem(), W'(1), 1'b0);
        run_mul(W'(1), rand_elem(), 1'b0);
        run_mul({W{1'b1}}, {W{1'b1}}, 1'b0);
        run_mul('0, {W{1'b1}}, 1'b0);
        // R4 skip patterns: long zero runs, top bit only, sparse bits
        run_mul(rand_elem(), W'(1) << (W-1), 1'b0);
        run_mul(rand_elem(), (W'(1) << 200) | (W'(1) << 6) | W'(1), 1'b0);
        run_mul({W{1'b1}}, W'(32'h8421_0840), 1'b0);
        // R2 start during a busy run is ignored
        run_mul(rand_elem(), {W{1'b1}}, 1'b1);
        // R1/R4 random dense and sparse operands
        for (int i = 0; i < 30; i++) begin
            ra = rand_elem();
            rb = rand_elem();
            if (i % 3 == 1) rb = rb & rand_elem() & rand_elem();
            if (i % 3 == 2) rb = rb & rand_elem() & rand_elem() & rand_elem() & rand_elem();
            run_mul(ra, rb, (i % 10 == 9));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule